// File: doc/BRIEF.md
# Buffered Compare Register Reload Controller

This block keeps a bank of compare values for a timer whose counter runs up and down in a triangle. Each bank entry has two copies. Software writes the shadow copy, and the live copy drives the compare outputs. The block can move shadow values to the live copies in one of two ways. In immediate mode, each entry is moved on its own shortly after it is written. In batch mode, the whole bank is moved in one cycle at a selected turning point of the counter.

In batch mode, a write to one designated entry (index 1) arms the batch move. That write raises a pending flag. The move then happens at the next counter peak or valley that is enabled. It happens only while the timer run bit is high and after that bit has risen. Software should write the bank only while the pending flag reads 0. In immediate mode, a second write that lands while the first move of the same entry is still in flight is held back. It is applied at the next peak if the counter was counting up, or at the next valley if it was counting down.

Top module: `cmp_reload_ctrl`

## Requirements
- R1: After reset, every live compare value is 0 and `reload_pend` is 0.
- R2: When `mode_imm` is 1 (immediate mode), a write to entry k is sampled at one rising edge and appears on `cmp_act[k*16 +: 16]` after the next edge. No other entry changes.
- R3: In immediate mode, a write to entry k in the cycle right after a write to k leaves the first value in place. The second value is applied at the next `peak_evt` if `cnt_up` was 1 at that write, or at the next `valley_evt` if `cnt_up` was 0. An event of the other kind leaves it held.
- R4: When `mode_imm` is 0 (batch mode), a write to entry 1 sets `reload_pend` at the next edge.
- R5: In batch mode, a write to any entry other than 1 changes only that entry's shadow copy. It neither sets `reload_pend` nor changes any live value.
- R6: At a valid reload point with `reload_pend` set, every live value takes its shadow copy at the same edge, and `reload_pend` clears at that edge.
- R7: `peak_en` lets `peak_evt` act as a reload point, and `valley_en` lets `valley_evt` act as one. An event whose enable is 0 leaves a pending reload waiting.
- R8: A reload point counts only while `start` is 1 and after `start` has been sampled rising from 0 to 1. While `start` is 0, a pending reload stays pending.
- R9: If a write to entry 1 lands in the same cycle as a reload, the reload uses the shadow values from before that write, and `reload_pend` stays 1.
- R10: With `peak_en` and `valley_en` both 0, a pending reload is held through any event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Entry index for the write |
| wr_data | input | 16 | Value written to the shadow copy |
| mode_imm | input | 1 | 1 = immediate mode, 0 = batch reload |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| peak_evt | input | 1 | One-cycle pulse at the counter peak |
| valley_evt | input | 1 | One-cycle pulse at the counter valley |
| peak_en | input | 1 | Allows peaks as reload points |
| valley_en | input | 1 | Allows valleys as reload points |
| start | input | 1 | Timer run bit |
| reload_pend | output | 1 | Batch reload armed and waiting |
| cmp_act | output | 128 | Live compare values, entry i at bits i*16 +: 16 |

## Verification
The bench writes every entry in immediate mode and checks the one-cycle latency. A design that moved the value at the write edge, or disturbed a neighbouring entry, would fail here. It writes the same entry back to back in both counter directions and then fires the wrong turning point first. A design that applied the second value at once, or picked its event from the wrong direction, would show the new value too early. In batch mode, it sweeps all four enable combinations against both event kinds, holds `start` low, and writes entry 1 in the very cycle of a reload. A design that cleared the flag in that cycle, or copied the freshly written value, would be caught.

// File: rtl/cmp_reload_pkg.sv
package cmp_reload_pkg;
  // Kind of counter turning point a held immediate write waits for
  typedef enum logic {
    TURN_VALLEY = 1'b0,
    TURN_PEAK   = 1'b1
  } turn_e;
endpackage

// File: rtl/cmp_start_gate.sv
// Arms reload handling once the run bit has been seen rising; drops it when the bit goes low.
module cmp_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic armed
);
  logic start_d_q, armed_q, armed_n;

  always_comb begin
    armed_n = start & (armed_q | ~start_d_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_d_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      start_d_q <= start;
      armed_q   <= armed_n;
    end
  end

  // gated with the live run bit so a falling start blocks reload at once
  assign armed = armed_q & start;
endmodule

// File: rtl/cmp_reload_arb.sv
// Holds the batch pending flag and issues the bank-wide load strobe.
module cmp_reload_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_wr,
  input  logic armed,
  input  logic peak_evt,
  input  logic valley_evt,
  input  logic peak_en,
  input  logic valley_en,
  output logic pend,
  output logic load
);
  logic pend_q, pend_n, turn_ok;

  always_comb begin
    turn_ok = (peak_evt & peak_en) | (valley_evt & valley_en);
    load    = pend_q & armed & turn_ok;
    pend_n  = pend_q;
    if (load)    pend_n = 1'b0;
    if (trig_wr) pend_n = 1'b1;   // a trigger in the load cycle re-arms
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  assign pend = pend_q;
endmodule

// File: rtl/cmp_bank_slot.sv
// One entry: shadow copy, live copy, immediate-mode transfer and deferral.
module cmp_bank_slot
  import cmp_reload_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          mode_imm,
  input  logic          cnt_up,
  input  logic          peak_evt,
  input  logic          valley_evt,
  input  logic          bank_load,
  output logic [DW-1:0] act
);
  logic [DW-1:0] shd_q, act_q;
  logic          busy_q, busy_n, dfr_q, dfr_n;
  turn_e         turn_q, turn_n;
  logic          imm_wr, dfr_fire, act_en;

  always_comb begin
    imm_wr   = wr_hit & mode_imm;
    dfr_fire = dfr_q & ((turn_q == TURN_PEAK) ? peak_evt : valley_evt);
    act_en   = bank_load | busy_q | dfr_fire;
    busy_n   = imm_wr & ~busy_q & ~dfr_q;
    dfr_n    = dfr_q & ~dfr_fire;
    turn_n   = turn_q;
    if (imm_wr & (busy_q | dfr_q)) begin
      dfr_n  = 1'b1;
      turn_n = cnt_up ? TURN_PEAK : TURN_VALLEY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      act_q  <= '0;
      busy_q <= 1'b0;
      dfr_q  <= 1'b0;
      turn_q <= TURN_VALLEY;
    end else begin
      if (wr_hit) shd_q <= wr_data;
      if (act_en) act_q <= shd_q;
      busy_q <= busy_n;
      dfr_q  <= dfr_n;
      turn_q <= turn_n;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/cmp_reload_ctrl.sv
module cmp_reload_ctrl #(
  parameter int NREG     = 8,
  parameter int DW       = 16,
  parameter int TRIG_IDX = 1,
  localparam int AW      = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             mode_imm,
  input  logic             cnt_up,
  input  logic             peak_evt,
  input  logic             valley_evt,
  input  logic             peak_en,
  input  logic             valley_en,
  input  logic             start,
  output logic             reload_pend,
  output logic [NREG*DW-1:0] cmp_act
);
  logic armed, bank_load, trig_wr;

  assign trig_wr = wr_en & ~mode_imm & (wr_addr == AW'(TRIG_IDX));

  cmp_start_gate u_gate (
    .clk(clk), .rst_n(rst_n), .start(start), .armed(armed)
  );

  cmp_reload_arb u_arb (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .armed(armed),
    .peak_evt(peak_evt), .valley_evt(valley_evt),
    .peak_en(peak_en), .valley_en(valley_en),
    .pend(reload_pend), .load(bank_load)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    cmp_bank_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en & (wr_addr == AW'(i))),
      .wr_data(wr_data), .mode_imm(mode_imm), .cnt_up(cnt_up),
      .peak_evt(peak_evt), .valley_evt(valley_evt),
      .bank_load(bank_load),
      .act(cmp_act[i*DW +: DW])
    );
  end
endmodule

// File: rtl/cmp_reload_chk.sv
module cmp_reload_chk #(
  parameter int NREG     = 8,
  parameter int DW       = 16,
  parameter int TRIG_IDX = 1,
  localparam int AW      = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic               mode_imm,
  input logic               peak_evt,
  input logic               valley_evt,
  input logic               peak_en,
  input logic               valley_en,
  input logic               start,
  input logic               reload_pend,
  input logic [NREG*DW-1:0] cmp_act
);
  // R1: reset clears the bank and the flag
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_clear: assert (reload_pend == 1'b0 && cmp_act == '0);
  end

  a_r4_trigger_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_imm && wr_en && wr_addr == AW'(TRIG_IDX)) |=> reload_pend);

  a_r5_other_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_imm && wr_en && wr_addr != AW'(TRIG_IDX) && !reload_pend) |=> !reload_pend);

  a_r5_batch_live_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_imm && !$past(mode_imm) && !peak_evt && !valley_evt) |=> $stable(cmp_act));

  a_r6_clear_at_turn: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reload_pend) |-> $past((peak_evt && peak_en) || (valley_evt && valley_en)) && $past(start));

  a_r7_disabled_turn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pend && !(peak_evt && peak_en) && !(valley_evt && valley_en)) |=> reload_pend);

  a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pend && !start) |=> reload_pend);

  a_r10_no_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_pend && !peak_en && !valley_en) |=> reload_pend);
endmodule

bind cmp_reload_ctrl cmp_reload_chk #(.NREG(NREG), .DW(DW), .TRIG_IDX(TRIG_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .mode_imm(mode_imm),
  .peak_evt(peak_evt), .valley_evt(valley_evt), .peak_en(peak_en), .valley_en(valley_en),
  .start(start), .reload_pend(reload_pend), .cmp_act(cmp_act)
);

// File: tb/tb_cmp_reload_ctrl.sv
module tb_cmp_reload_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n, wr_en, mode_imm, cnt_up, peak_evt, valley_evt, peak_en, valley_en, start;
  logic [2:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic reload_pend;
  logic [NREG*DW-1:0] cmp_act;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] exp_act [NREG];
  logic [DW-1:0] exp_shd [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_reload_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_imm(mode_imm), .cnt_up(cnt_up), .peak_evt(peak_evt), .valley_evt(valley_evt),
    .peak_en(peak_en), .valley_en(valley_en), .start(start),
    .reload_pend(reload_pend), .cmp_act(cmp_act)
  );

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_pend(input string req, input logic exp);
    chk(reload_pend === exp, req, {15'd0, reload_pend}, {15'd0, exp});
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(cmp_act[i*DW +: DW] === exp_act[i], req, cmp_act[i*DW +: DW], exp_act[i]);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit pk);
    if (pk) peak_evt = 1'b1; else valley_evt = 1'b1;
    cyc();
    peak_evt = 1'b0; valley_evt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; mode_imm = 1'b1; cnt_up = 1'b1;
    peak_evt = 1'b0; valley_evt = 1'b0; peak_en = 1'b1; valley_en = 1'b1; start = 1'b0;
    for (int i = 0; i < NREG; i++) begin exp_act[i] = '0; exp_shd[i] = '0; end
    repeat (3) @(negedge clk);
    chk_bank("R1 reset live"); chk_pend("R1 reset pend", 1'b0);
    rst_n = 1'b1;
    cyc();

    // R2: immediate sweep over every entry, one-cycle latency
    for (int i = 0; i < NREG; i++) begin
      logic [DW-1:0] v;
      v = DW'(i * 16'h1111) ^ 16'h00A5;
      wr(i, v);
      chk_bank("R2 not yet moved");
      cyc();
      exp_act[i] = v; exp_shd[i] = v;
      chk_bank("R2 immediate moved");
    end

    // R3: back-to-back writes, counting up -> waits for peak
    cnt_up = 1'b1;
    wr(3, 16'hAAAA);
    wr(3, 16'hBBBB);
    cyc();
    exp_act[3] = 16'hAAAA; exp_shd[3] = 16'hBBBB;
    chk_bank("R3 first value kept");
    pulse(0);
    chk_bank("R3 valley ignored while up");
    pulse(1);
    exp_act[3] = 16'hBBBB;
    chk_bank("R3 applied at peak");
    // counting down -> waits for valley
    cnt_up = 1'b0;
    wr(6, 16'hCCCC);
    wr(6, 16'hDDDD);
    cyc();
    exp_act[6] = 16'hCCCC; exp_shd[6] = 16'hDDDD;
    chk_bank("R3 first value kept down");
    pulse(1);
    chk_bank("R3 peak ignored while down");
    pulse(0);
    exp_act[6] = 16'hDDDD;
    chk_bank("R3 applied at valley");

    // batch mode
    mode_imm = 1'b0; cyc();
    for (int i = 0; i < NREG; i++) begin
      if (i != 1) begin
        exp_shd[i] = DW'(16'h5000 + i * 16'h0101);
        wr(i, exp_shd[i]);
        chk_pend("R5 non-trigger no arm", 1'b0);
      end
    end
    cyc();
    chk_bank("R5 live unchanged");
    exp_shd[1] = 16'h7171;
    wr(1, exp_shd[1]);
    chk_pend("R4 trigger arms", 1'b1);
    chk_bank("R4 live unchanged before reload");
    pulse(1);
    chk_pend("R8 held while stopped", 1'b1);
    chk_bank("R8 no move while stopped");
    start = 1'b1; cyc();
    peak_en = 1'b0; valley_en = 1'b0;
    pulse(1); pulse(0);
    chk_pend("R10 held with no enable", 1'b1);
    chk_bank("R10 no move with no enable");
    valley_en = 1'b1;
    pulse(1);
    chk_pend("R7 peak disabled held", 1'b1);
    pulse(0);
    for (int i = 0; i < NREG; i++) exp_act[i] = exp_shd[i];
    chk_pend("R6 flag cleared", 1'b0);
    chk_bank("R6 bank moved together");

    // R9: trigger write in the reload cycle
    peak_en = 1'b1;
    wr(1, 16'h1234);
    chk_pend("R9 armed", 1'b1);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h5678; peak_evt = 1'b1;
    cyc();
    wr_en = 1'b0; peak_evt = 1'b0;
    exp_act[1] = 16'h1234;
    chk_pend("R9 flag stays set", 1'b1);
    chk_bank("R9 old shadow used");
    pulse(1);
    exp_act[1] = 16'h5678;
    chk_pend("R9 second reload clears", 1'b0);
    chk_bank("R9 second reload value");

    // R7 sweep: enable combinations against both event kinds
    for (int en = 0; en < 4; en++) begin
      for (int ev = 0; ev < 2; ev++) begin
        bit exp_clear;
        peak_en = 1'b1; valley_en = 1'b1;
        wr(1, 16'h5678);
        peak_en = en[1]; valley_en = en[0];
        pulse(ev[0]);
        exp_clear = ev[0] ? en[1] : en[0];
        chk_pend("R7 enable sweep", !exp_clear);
        peak_en = 1'b1; valley_en = 1'b1;
        pulse(1);
        chk_pend("R7 sweep cleanup", 1'b0);
        chk_bank("R7 sweep bank");
      end
    end

    // R8: dropping start blocks a pending reload
    start = 1'b0;
    exp_shd[5] = 16'h0F0F;
    wr(5, 16'h0F0F);
    wr(1, 16'h5678);
    pulse(1); pulse(0);
    chk_pend("R8 stopped hold", 1'b1);
    chk_bank("R8 stopped bank");
    start = 1'b1; cyc();
    pulse(0);
    exp_act[5] = 16'h0F0F;
    chk_pend("R8 restart reload", 1'b0);
    chk_bank("R8 restart bank");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule